// File: doc/BRIEF.md
# Memory card access decoder

The block sits between a host bus and the byte-wide storage of a removable memory card. Each clock it samples two active-low card enables, one for the low data lane and one for the high data lane, plus address bit 0, a word address, an attribute-space select, output enable, write enable and the position of a write-protect switch. From these it decides one access state. That state then drives the chip selects and write strobes of the two byte banks (even and odd bytes), the byte-steering control that moves an odd byte onto the low lane, and the output enables of the two 8-bit halves of the 16-bit data bus.

The enables choose the bus shape. The low enable alone gives a byte access on the low lane, and address bit 0 picks the byte. The high enable alone gives an odd-byte access on the high lane. Both enables together give a 16-bit word access. A write-protected write collapses to output-disable.

Attribute space is served in one of two ways, chosen by a parameter. One way is a small byte store of its own. The other is a constant all-ones answer that ignores writes. The storage is a model of byte-wide banks, cleared on reset.

A small state machine holds the access state with four states: `ST_STANDBY`, `ST_READ`, `ST_WRITE` and `ST_ODIS`. Every cycle it moves from any state to the state decoded from the inputs:
- **Standby entry**: both enables are high.
- **Write entry**: an enable is low, write enable is low and the switch is off.
- **Read entry**: an enable is low, output enable is low and write enable is high.
- **Disable entry**: any other enabled case, which covers output enable high and protected writes.

Outputs follow the state registered at the previous rising edge. A write reaches the banks at the edge after the `ST_WRITE` state is entered.

Top module: `mcard_decoder`

## Requirements
- R1: With both enables high the state is standby. Both lane output enables are 0, `rd_data` is 0, and no chip select or write strobe is active. The same holds during and right after reset.
- R2: With only `ce_lo_n` low, a read drives the low lane only. `a0`=0 returns the even byte. `a0`=1 returns the odd byte on bits 7:0, with `steer_odd_lo`=1.
- R3: With only `ce_hi_n` low, a read drives bits 15:8 with the odd byte whatever `a0` is, and `bank_cs_even` stays 0.
- R4: With both enables low, a read drives both lanes whatever `a0` is: the even byte on bits 7:0 and the odd byte on bits 15:8.
- R5: A main-space write stores data as follows. With the low enable only, `wr_data[7:0]` goes to the even byte (`a0`=0) or the odd byte (`a0`=1). With the high enable only, `wr_data[15:8]` goes to the odd byte. With both enables, both bytes are written. The matching `bank_we_*` strobes are set.
- R6: With `wp_sw`=1, a cycle that would write becomes output-disable. No strobe is set, no lane is driven and storage is unchanged.
- R7: A read needs `oe_n`=0 and `we_n`=1. With `oe_n`=1 and `we_n`=1, both lanes are off and `rd_data` is 0.
- R8: With `we_n`=0 and `oe_n`=0 together, the cycle is a write and both lanes are off.
- R9: Attribute space (`attr_n`=0) never selects a main bank. With `ATTR_STORED`=0, a read returns 0xFF on the low lane when the low enable is active, and writes have no effect.
- R10: In attribute space, the high lane reads all ones when the high enable is active. With `ATTR_STORED`=1, a write with the low enable active stores `wr_data[7:0]` at index {`addr`,`a0`}, where `a0` counts as 0 when both enables are low. A later read returns that byte on the low lane.
- R11: `wp_status` is 0 when writes are allowed and 1 when the switch protects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_lo_n | input | 1 | Low-lane card enable, active low |
| ce_hi_n | input | 1 | High-lane card enable, active low |
| a0 | input | 1 | Byte address bit 0 |
| addr | input | ADDR_W | Word address |
| attr_n | input | 1 | Attribute-space select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_sw | input | 1 | Write-protect switch, 1 = protect |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Read data, 0 on a lane that is not driven |
| lane_lo_oe | output | 1 | Drive enable for bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for bits 15:8 |
| bank_cs_even | output | 1 | Even-byte bank select |
| bank_cs_odd | output | 1 | Odd-byte bank select |
| bank_we_even | output | 1 | Even-byte bank write strobe |
| bank_we_odd | output | 1 | Odd-byte bank write strobe |
| steer_odd_lo | output | 1 | Odd byte routed onto bits 7:0 |
| wp_status | output | 1 | Write-protect status |

## Verification
The bench builds two copies of the block side by side on the same inputs: one with `ATTR_STORED`=0 and one with `ATTR_STORED`=1, both with `ADDR_W`=4. Having both copies puts the constant attribute answer and the stored attribute byte within reach in the same run. The 16-word banks are small enough that random addresses often hit bytes written earlier, so read-back of every lane shape after 8-bit and 16-bit writes gets exercised. Every combination of the two enables, `a0`, attribute select, output enable, write enable and protect switch is applied, then a long random run and a few directed write/read-back sequences.

// File: rtl/mcard_pkg.sv
`timescale 1ns/1ps
package mcard_pkg;

    // Access state held by the controller for one cycle
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_READ    = 2'd1,
        ST_WRITE   = 2'd2,
        ST_ODIS    = 2'd3
    } acc_state_t;

    // Which enables are active: bit 1 = high lane, bit 0 = low lane
    typedef enum logic [1:0] {
        LN_NONE = 2'd0,
        LN_LO   = 2'd1,
        LN_HI   = 2'd2,
        LN_BOTH = 2'd3
    } lane_cfg_t;

    typedef struct packed {
        acc_state_t st;
        lane_cfg_t  lanes;
        logic       a0;
        logic       attr;
    } acc_req_t;

endpackage

// File: rtl/mcard_access_decode.sv
`timescale 1ns/1ps
module mcard_access_decode
    import mcard_pkg::*;
(
    input  logic     ce_lo_n,
    input  logic     ce_hi_n,
    input  logic     a0,
    input  logic     attr_n,
    input  logic     oe_n,
    input  logic     we_n,
    input  logic     wp_sw,
    output acc_req_t req
);

    always_comb begin
        req.lanes = lane_cfg_t'({~ce_hi_n, ~ce_lo_n});
        req.a0    = a0;
        req.attr  = ~attr_n;
        if (ce_lo_n && ce_hi_n) begin
            req.st = ST_STANDBY;
        end else if (!we_n) begin
            // write wins over output enable; protect turns it into disable
            req.st = wp_sw ? ST_ODIS : ST_WRITE;
        end else if (!oe_n) begin
            req.st = ST_READ;
        end else begin
            req.st = ST_ODIS;
        end
    end

endmodule

// File: rtl/mcard_access_fsm.sv
`timescale 1ns/1ps
module mcard_access_fsm
    import mcard_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_req_t          req,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [15:0]       wdata_in,
    output acc_state_t        state_q,
    output lane_cfg_t         lanes_q,
    output logic              a0_q,
    output logic              attr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [15:0]       wdata_q,
    output logic              lane_lo_oe,
    output logic              lane_hi_oe,
    output logic              cs_even,
    output logic              cs_odd,
    output logic              we_even,
    output logic              we_odd,
    output logic              steer_odd_lo
);

    logic sel_even;
    logic sel_odd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= req.st;
        end
    end

    // Access context captured alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= LN_NONE;
            a0_q    <= 1'b0;
            attr_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            lanes_q <= req.lanes;
            a0_q    <= req.a0;
            attr_q  <= req.attr;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_comb begin
        sel_even = (lanes_q == LN_BOTH) || ((lanes_q == LN_LO) && !a0_q);
        sel_odd  = (lanes_q == LN_HI) || (lanes_q == LN_BOTH) ||
                   ((lanes_q == LN_LO) && a0_q);
    end

    // Output decode
    always_comb begin
        lane_lo_oe   = 1'b0;
        lane_hi_oe   = 1'b0;
        cs_even      = 1'b0;
        cs_odd       = 1'b0;
        we_even      = 1'b0;
        we_odd       = 1'b0;
        steer_odd_lo = 1'b0;
        unique case (state_q)
            ST_STANDBY: begin
            end
            ST_READ: begin
                lane_lo_oe   = (lanes_q == LN_LO) || (lanes_q == LN_BOTH);
                lane_hi_oe   = (lanes_q == LN_HI) || (lanes_q == LN_BOTH);
                cs_even      = !attr_q && sel_even;
                cs_odd       = !attr_q && sel_odd;
                steer_odd_lo = !attr_q && (lanes_q == LN_LO) && a0_q;
            end
            ST_WRITE: begin
                cs_even = !attr_q && sel_even;
                cs_odd  = !attr_q && sel_odd;
                we_even = !attr_q && sel_even;
                we_odd  = !attr_q && sel_odd;
            end
            ST_ODIS: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mcard_byte_bank.sv
`timescale 1ns/1ps
module mcard_byte_bank #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'h00;
            end
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/mcard_decoder.sv
`timescale 1ns/1ps
module mcard_decoder
    import mcard_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter bit ATTR_STORED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lo_n,
    input  logic              ce_hi_n,
    input  logic              a0,
    input  logic [ADDR_W-1:0] addr,
    input  logic              attr_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp_sw,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              lane_lo_oe,
    output logic              lane_hi_oe,
    output logic              bank_cs_even,
    output logic              bank_cs_odd,
    output logic              bank_we_even,
    output logic              bank_we_odd,
    output logic              steer_odd_lo,
    output logic              wp_status
);

    localparam int ATTR_AW = ADDR_W + 1;

    acc_req_t          req;
    acc_state_t        state_q;
    lane_cfg_t         lanes_q;
    logic              a0_q;
    logic              attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       wdata_q;
    logic [7:0]        even_byte;
    logic [7:0]        odd_byte;
    logic [7:0]        attr_byte;

    mcard_access_decode u_decode (
        .ce_lo_n (ce_lo_n),
        .ce_hi_n (ce_hi_n),
        .a0      (a0),
        .attr_n  (attr_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .wp_sw   (wp_sw),
        .req     (req)
    );

    mcard_access_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .addr_in      (addr),
        .wdata_in     (wr_data),
        .state_q      (state_q),
        .lanes_q      (lanes_q),
        .a0_q         (a0_q),
        .attr_q       (attr_q),
        .addr_q       (addr_q),
        .wdata_q      (wdata_q),
        .lane_lo_oe   (lane_lo_oe),
        .lane_hi_oe   (lane_hi_oe),
        .cs_even      (bank_cs_even),
        .cs_odd       (bank_cs_odd),
        .we_even      (bank_we_even),
        .we_odd       (bank_we_odd),
        .steer_odd_lo (steer_odd_lo)
    );

    // Even bank takes the low lane; odd bank takes the high lane in
    // 16-bit and high-only writes, the low lane in low-only writes.
    mcard_byte_bank #(.AW(ADDR_W)) u_even (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_we_even),
        .addr  (addr_q),
        .wdata (wdata_q[7:0]),
        .rdata (even_byte)
    );

    mcard_byte_bank #(.AW(ADDR_W)) u_odd (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bank_we_odd),
        .addr  (addr_q),
        .wdata ((lanes_q == LN_LO) ? wdata_q[7:0] : wdata_q[15:8]),
        .rdata (odd_byte)
    );

    generate
        if (ATTR_STORED) begin : g_attr_store
            logic [ATTR_AW-1:0] attr_idx;
            logic               attr_we;
            assign attr_idx = {addr_q, a0_q & (lanes_q != LN_BOTH)};
            assign attr_we  = (state_q == ST_WRITE) && attr_q &&
                              ((lanes_q == LN_LO) || (lanes_q == LN_BOTH));
            mcard_byte_bank #(.AW(ATTR_AW)) u_attr (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (attr_we),
                .addr  (attr_idx),
                .wdata (wdata_q[7:0]),
                .rdata (attr_byte)
            );
        end else begin : g_attr_const
            assign attr_byte = 8'hFF;
        end
    endgenerate

    always_comb begin
        rd_data = 16'h0000;
        if (lane_lo_oe) begin
            if (attr_q)            rd_data[7:0] = attr_byte;
            else if (steer_odd_lo) rd_data[7:0] = odd_byte;
            else                   rd_data[7:0] = even_byte;
        end
        if (lane_hi_oe) begin
            rd_data[15:8] = attr_q ? 8'hFF : odd_byte;
        end
    end

    assign wp_status = wp_sw;

endmodule

// File: rtl/mcard_decoder_chk.sv
`timescale 1ns/1ps
module mcard_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_lo_n,
    input logic ce_hi_n,
    input logic attr_n,
    input logic oe_n,
    input logic we_n,
    input logic wp_sw,
    input logic lane_lo_oe,
    input logic lane_hi_oe,
    input logic bank_cs_even,
    input logic bank_cs_odd,
    input logic bank_we_even,
    input logic bank_we_odd
);

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && ce_hi_n) |=> (!lane_lo_oe && !lane_hi_oe && !bank_cs_even && !bank_cs_odd));

    p_hi_only_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_lo_n && !ce_hi_n) |=> !bank_cs_even);

    p_word_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_lo_n && !ce_hi_n && !oe_n && we_n) |=> (lane_lo_oe && lane_hi_oe));

    p_protect_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wp_sw |=> (!bank_we_even && !bank_we_odd));

    p_oe_high_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && we_n) |=> (!lane_lo_oe && !lane_hi_oe));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !oe_n) |=> (!lane_lo_oe && !lane_hi_oe));

    p_attr_no_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !attr_n |=> (!bank_cs_even && !bank_cs_odd));

endmodule

bind mcard_decoder mcard_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_lo_n      (ce_lo_n),
    .ce_hi_n      (ce_hi_n),
    .attr_n       (attr_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .wp_sw        (wp_sw),
    .lane_lo_oe   (lane_lo_oe),
    .lane_hi_oe   (lane_hi_oe),
    .bank_cs_even (bank_cs_even),
    .bank_cs_odd  (bank_cs_odd),
    .bank_we_even (bank_we_even),
    .bank_we_odd  (bank_we_odd)
);

// File: tb/mcard_decoder_tb_top.sv
`timescale 1ns/1ps
module mcard_decoder_tb_top;

    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, a0 = 1'b0, attr_n = 1'b1;
    logic oe_n = 1'b1, we_n = 1'b1, wp_sw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;

    logic [15:0] c_rd, s_rd;
    logic c_lo, c_hi, c_ce, c_co, c_we, c_wo, c_st, c_wp;
    logic s_lo, s_hi, s_ce, s_co, s_we, s_wo, s_st, s_wp;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ev [1 << AW];
    logic [7:0] m_od [1 << AW];
    logic [7:0] m_at [1 << (AW + 1)];

    mcard_decoder #(.ADDR_W(AW), .ATTR_STORED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
        .addr(addr), .attr_n(attr_n), .oe_n(oe_n), .we_n(we_n), .wp_sw(wp_sw),
        .wr_data(wdata), .rd_data(c_rd), .lane_lo_oe(c_lo), .lane_hi_oe(c_hi),
        .bank_cs_even(c_ce), .bank_cs_odd(c_co), .bank_we_even(c_we), .bank_we_odd(c_wo),
        .steer_odd_lo(c_st), .wp_status(c_wp));

    mcard_decoder #(.ADDR_W(AW), .ATTR_STORED(1'b1)) dut_s (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
        .addr(addr), .attr_n(attr_n), .oe_n(oe_n), .we_n(we_n), .wp_sw(wp_sw),
        .wr_data(wdata), .rd_data(s_rd), .lane_lo_oe(s_lo), .lane_hi_oe(s_hi),
        .bank_cs_even(s_ce), .bank_cs_odd(s_co), .bank_we_even(s_we), .bank_we_odd(s_wo),
        .steer_odd_lo(s_st), .wp_status(s_wp));

    // Expected {lo_oe, hi_oe, cs_even, cs_odd, we_even, we_odd, steer, data[15:0]}
    function automatic logic [22:0] ref_out(input bit stored);
        logic lo_act, hi_act, rd, wr, mainsp, lo_oe, hi_oe, cse, cso, wee, weo, st;
        logic [15:0] d;
        lo_act = !ce_lo_n;
        hi_act = !ce_hi_n;
        if (!lo_act && !hi_act) return 23'd0;
        wr = !we_n && !wp_sw;
        rd = we_n && !oe_n;
        mainsp = attr_n;
        lo_oe = rd && lo_act;
        hi_oe = rd && hi_act;
        cse = mainsp && (rd || wr) && lo_act && (hi_act || !a0);
        cso = mainsp && (rd || wr) && (hi_act || a0);
        wee = wr && cse;
        weo = wr && cso;
        st  = mainsp && rd && lo_act && !hi_act && a0;
        d = 16'h0000;
        if (lo_oe) begin
            if (mainsp) d[7:0] = (hi_act || !a0) ? m_ev[addr] : m_od[addr];
            else        d[7:0] = stored ? m_at[{addr, a0 & !hi_act}] : 8'hFF;
        end
        if (hi_oe) d[15:8] = mainsp ? m_od[addr] : 8'hFF;
        return {lo_oe, hi_oe, cse, cso, wee, weo, st, d};
    endfunction

    function automatic string tag_of(input bit stored);
        if (ce_lo_n && ce_hi_n)   return "R1";
        if (!we_n && wp_sw)       return "R6";
        if (!attr_n)              return stored ? "R10" : "R9";
        if (!we_n && !oe_n)       return "R8";
        if (!we_n)                return "R5";
        if (oe_n)                 return "R7";
        if (!ce_lo_n && ce_hi_n)  return "R2";
        if (ce_lo_n && !ce_hi_n)  return "R3";
        return "R4";
    endfunction

    task automatic check_now();
        logic [22:0] exp_c, exp_s, got_c, got_s;
        exp_c = ref_out(1'b0);
        exp_s = ref_out(1'b1);
        got_c = {c_lo, c_hi, c_ce, c_co, c_we, c_wo, c_st, c_rd};
        got_s = {s_lo, s_hi, s_ce, s_co, s_we, s_wo, s_st, s_rd};
        checks++;
        if (got_c !== exp_c) begin
            errors++;
            $display("FAIL %s const-attr actual=%h expected=%h", tag_of(1'b0), got_c, exp_c);
        end
        checks++;
        if (got_s !== exp_s) begin
            errors++;
            $display("FAIL %s stored-attr actual=%h expected=%h", tag_of(1'b1), got_s, exp_s);
        end
        // R11: status mirrors the switch
        checks++;
        if (c_wp !== wp_sw || s_wp !== wp_sw) begin
            errors++;
            $display("FAIL R11 actual=%b/%b expected=%b", c_wp, s_wp, wp_sw);
        end
    endtask

    task automatic update_model();
        logic lo_act, hi_act;
        lo_act = !ce_lo_n;
        hi_act = !ce_hi_n;
        if ((lo_act || hi_act) && !we_n && !wp_sw) begin
            if (attr_n) begin
                if (lo_act && hi_act) begin
                    m_ev[addr] = wdata[7:0];
                    m_od[addr] = wdata[15:8];
                end else if (lo_act) begin
                    if (a0) m_od[addr] = wdata[7:0];
                    else    m_ev[addr] = wdata[7:0];
                end else begin
                    m_od[addr] = wdata[15:8];
                end
            end else if (lo_act) begin
                m_at[{addr, a0 & !hi_act}] = wdata[7:0];
            end
        end
    endtask

    // Called at a falling edge: drive, wait one cycle, check, update model
    task automatic run_vec(input logic cl, input logic ch, input logic a, input logic at,
                           input logic oe, input logic we, input logic wp,
                           input logic [AW-1:0] ad, input logic [15:0] wd);
        ce_lo_n = cl; ce_hi_n = ch; a0 = a; attr_n = at;
        oe_n = oe; we_n = we; wp_sw = wp; addr = ad; wdata = wd;
        @(negedge clk);
        check_now();
        update_model();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) begin
            m_ev[i] = 8'h00;
            m_od[i] = 8'h00;
        end
        for (int i = 0; i < (1 << (AW + 1)); i++) m_at[i] = 8'h00;

        // R1: reset state
        repeat (2) @(negedge clk);
        check_now();
        rst_n = 1'b1;
        @(negedge clk);
        check_now();

        // R5, R2, R3, R4: word write then every read shape
        run_vec(0, 0, 0, 1, 1, 0, 0, 4'd5, 16'hBEEF);
        run_vec(0, 1, 0, 1, 0, 1, 0, 4'd5, 16'h0000);
        run_vec(0, 1, 1, 1, 0, 1, 0, 4'd5, 16'h0000);
        run_vec(1, 0, 0, 1, 0, 1, 0, 4'd5, 16'h0000);
        // R6: protected write leaves the word intact
        run_vec(0, 0, 0, 1, 1, 0, 1, 4'd5, 16'h1234);
        run_vec(0, 0, 1, 1, 0, 1, 0, 4'd5, 16'h0000);
        // R5: byte writes on each lane shape, then word read-back
        run_vec(0, 1, 1, 1, 1, 0, 0, 4'd9, 16'h00A5);
        run_vec(0, 1, 0, 1, 1, 0, 0, 4'd9, 16'h003C);
        run_vec(1, 0, 1, 1, 1, 0, 0, 4'd7, 16'h7700);
        run_vec(0, 0, 0, 1, 0, 1, 0, 4'd9, 16'h0000);
        run_vec(0, 0, 0, 1, 0, 1, 0, 4'd7, 16'h0000);
        // R10 / R9: attribute write then reads in both widths
        run_vec(0, 1, 1, 0, 1, 0, 0, 4'd2, 16'hFF5A);
        run_vec(0, 1, 1, 0, 0, 1, 0, 4'd2, 16'h0000);
        run_vec(0, 0, 0, 0, 1, 0, 0, 4'd3, 16'h00C3);
        run_vec(0, 0, 1, 0, 0, 1, 0, 4'd3, 16'h0000);
        run_vec(1, 0, 0, 0, 0, 1, 0, 4'd3, 16'h0000);

        // Every control combination, R1..R11
        for (int v = 0; v < 128; v++) begin
            run_vec(v[0], v[1], v[2], v[3], v[4], v[5], v[6],
                    AW'($urandom), 16'($urandom));
        end

        // Random run
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] c;
            c = 7'($urandom);
            run_vec(c[0], c[1], c[2], c[3], c[4], c[5], ($urandom % 4) == 0,
                    AW'($urandom), 16'($urandom));
        end

        // R1: back to standby
        run_vec(1, 1, 0, 1, 0, 1, 0, 4'd0, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule